// File: doc/BRIEF.md
# Per-Channel Tap Shift Unit

This block stands in for a 3x3 spatial convolution in a low-precision network datapath. It moves every channel of a streamed feature map by at most one pixel, with no arithmetic. Each channel is given a fixed direction from its index, and one of those directions means the channel is left in place. Pixels arrive in raster order, one channel vector per handshake beat. The block keeps the two previous image rows in line stores and the two previous columns in registers. From these it forms a 3x3 neighbourhood around each output pixel. Each channel lane then takes the one neighbour that its direction names.

The image is treated as surrounded by a one-pixel border of zeros. A neighbour that falls outside the image therefore reads as zero, whatever the line stores hold. The width and height are given at run time and are captured by a one-cycle frame-start pulse. That pulse also clears the scan position. The output image has the same size as the input and leaves in raster order through a ready/valid port that can be stalled at any time.

Top module: `chan_shift_unit`

## Requirements
- R1: Lane `k` of a beat carries channel `k` in bits `[k*DW +: DW]`. For channel `k`, let `t = k mod 9`, `dr = t/3 - 1` (integer division) and `dc = t mod 3 - 1`. Output pixel (row r, column c) of that lane then equals input pixel (r+dr, c+dc) of the same lane.
- R2: When (r+dr, c+dc) lies outside the image, the lane value is zero. For example, a lane with `t = 3` is zero in column 0.
- R3: Lanes with `t = 4` pass the input through unchanged. A channel index of 9 or more uses the same direction as its index minus 9.
- R4: For each frame the block accepts exactly W*H input beats and emits exactly W*H output beats, row by row from row 0, and left to right within a row.
- R5: `img_w` (1..MAX_W) and `img_h` (1..MAX_H) are sampled in the cycle that `sof` is high and hold for the whole frame. Consecutive frames may use different sizes.
- R6: A `sof` pulse restarts the scan at row 0, column 0, even in the middle of a frame. No pixel from an earlier frame appears in the output of the new frame.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. No beat is lost or repeated under stalls on either side.
- R8: With input always valid and output always ready, the last output beat of a W x H frame is accepted (H+1)*(W+1)+1 clock edges after the edge that samples `sof`.
- R9: After reset and before the first `sof`, `out_valid` and `in_ready` are low and no input beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| sof | input | 1 | One-cycle frame-start pulse; samples the size and restarts the scan |
| img_w | input | $clog2(MAX_W+1) | Image width in pixels |
| img_h | input | $clog2(MAX_H+1) | Image height in rows |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_data | input | NCH*DW | Input channel vector, lane k at [k*DW +: DW] |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | NCH*DW | Shifted channel vector, same lane layout |

## Verification
The assertions assume that `sof` is never high in a cycle where `in_valid` is high. They also assume that the sampled width and height are at least one and no larger than the parameters allow. Under those conditions they check the following: the scan position stays inside the padded grid, input is taken only at real pixel positions, the size registers hold during a frame, stalled output holds, and top-row neighbours are masked. The bench lowers `in_valid` in the same cycle it raises `sof`, and drains or stops the previous stream first. Every size it uses lies within 1..16. Random gaps on the input and random stalls on the output exercise the handshakes without breaking these assumptions.

// File: rtl/tapshift_pkg.sv
package tapshift_pkg;

  localparam int unsigned TAP_SIDE   = 3;
  localparam int unsigned TAP_COUNT  = TAP_SIDE * TAP_SIDE;
  localparam int unsigned TAP_CENTRE = TAP_COUNT / 2;
  localparam int unsigned LINE_COUNT = TAP_SIDE - 1;

  // direction of a channel: neighbourhood position in raster order
  function automatic int unsigned tap_of(input int unsigned ch);
    return ch % TAP_COUNT;
  endfunction

  function automatic int unsigned tap_row(input int unsigned tap);
    return tap / TAP_SIDE;
  endfunction

  function automatic int unsigned tap_col(input int unsigned tap);
    return tap % TAP_SIDE;
  endfunction

endpackage

// File: rtl/tapshift_scan_ctrl.sv
module tapshift_scan_ctrl #(
  parameter int unsigned MAX_W = 16,
  parameter int unsigned MAX_H = 16,
  localparam int unsigned CW = $clog2(MAX_W + 1),
  localparam int unsigned RW = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic [CW-1:0] img_w,
  input  logic [RW-1:0] img_h,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          step,
  output logic          emit,
  output logic          real_px,
  output logic          col_write,
  output logic [CW-1:0] col_idx,
  output logic [2:0]    row_ok,
  output logic [2:0]    col_ok
);

  logic          active_q, active_d;
  logic [RW-1:0] row_q, row_d, hgt_q, hgt_d;
  logic [CW-1:0] col_q, col_d, wid_q, wid_d;
  logic          ovld_q, ovld_d;
  logic          sink_ok, src_ok;

  // scan walks a (H+1) x (W+1) grid; last row and column are zero padding
  always_comb begin
    real_px   = active_q && (row_q < hgt_q) && (col_q < wid_q);
    sink_ok   = !ovld_q || out_ready;
    src_ok    = active_q && (!real_px || in_valid);
    step      = src_ok && sink_ok && !sof;
    emit      = (row_q != '0) && (col_q != '0);
    in_ready  = real_px && sink_ok;
    col_write = step && (col_q < wid_q);
    col_idx   = col_q;
    // index 0: two rows/cols back, 1: centre, 2: newest
    row_ok    = {row_q < hgt_q, 1'b1, row_q >= RW'(2)};
    col_ok    = {col_q < wid_q, 1'b1, col_q >= CW'(2)};
    out_valid = ovld_q;
  end

  always_comb begin
    active_d = active_q;
    row_d    = row_q;
    col_d    = col_q;
    wid_d    = wid_q;
    hgt_d    = hgt_q;
    if (sof) begin
      active_d = 1'b1;
      row_d    = '0;
      col_d    = '0;
      wid_d    = img_w;
      hgt_d    = img_h;
    end else if (step) begin
      if (col_q == wid_q) begin
        col_d = '0;
        if (row_q == hgt_q) active_d = 1'b0;
        else                row_d    = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
    ovld_d = ovld_q;
    if (step && emit)   ovld_d = 1'b1;
    else if (out_ready) ovld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      wid_q    <= '0;
      hgt_q    <= '0;
      ovld_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      row_q    <= row_d;
      col_q    <= col_d;
      wid_q    <= wid_d;
      hgt_q    <= hgt_d;
      ovld_q   <= ovld_d;
    end
  end

  p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (row_q <= hgt_q) && (col_q <= wid_q));

  p_take_real_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (row_q < hgt_q) && (col_q < wid_q));

  p_size_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sof) |=> $stable(wid_q) && $stable(hgt_q));

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovld_q && !out_ready) |=> ovld_q);

endmodule

// File: rtl/tapshift_line_store.sv
module tapshift_line_store #(
  parameter int unsigned MAX_W = 16,
  parameter int unsigned VW    = 48,
  localparam int unsigned CW    = $clog2(MAX_W + 1),
  localparam int unsigned AW    = (MAX_W > 1) ? $clog2(MAX_W) : 1,
  localparam int unsigned LINES = tapshift_pkg::LINE_COUNT
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [CW-1:0]             addr,
  input  logic [VW-1:0]             wr_data,
  output logic [LINES-1:0][VW-1:0]  rd_rows
);

  logic [AW-1:0] a;
  assign a = addr[AW-1:0];

  // line 0 holds the row above, line i the row i+1 above; a write cascades
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [VW-1:0] mem [MAX_W];
    logic [VW-1:0] din;
    if (i == 0) begin : g_head
      assign din = wr_data;
    end else begin : g_tail
      assign din = rd_rows[i-1];
    end
    assign rd_rows[i] = mem[a];
    always_ff @(posedge clk) begin
      if (wr_en) mem[a] <= din;
    end
  end

endmodule

// File: rtl/tapshift_window.sv
module tapshift_window #(
  parameter int unsigned NCH = 12,
  parameter int unsigned DW  = 4,
  localparam int unsigned VW   = NCH * DW,
  localparam int unsigned SIDE = tapshift_pkg::TAP_SIDE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic [SIDE-1:0][VW-1:0]  col_new,
  input  logic [SIDE-1:0]          row_ok,
  input  logic [SIDE-1:0]          col_ok,
  output logic [VW-1:0]            sel
);

  logic [SIDE-1:0][VW-1:0] back2_q, back2_d, back1_q, back1_d;
  logic [SIDE-1:0][SIDE-1:0][VW-1:0] win;   // [column][row]

  always_comb begin
    back2_d = step ? back1_q : back2_q;
    back1_d = step ? col_new : back1_q;
  end

  always_ff @(posedge clk) begin
    back2_q <= back2_d;
    back1_q <= back1_d;
  end

  assign win[0] = back2_q;
  assign win[1] = back1_q;
  assign win[2] = col_new;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    localparam int unsigned TP = tapshift_pkg::tap_of(ch);
    localparam int unsigned TJ = TP / SIDE;
    localparam int unsigned TK = TP % SIDE;
    logic [DW-1:0] lane;
    assign lane = win[TK][TJ][ch*DW +: DW];
    assign sel[ch*DW +: DW] = (row_ok[TJ] && col_ok[TK]) ? lane : '0;

    if (TJ == 0) begin : g_top_chk
      p_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !row_ok[0]) |-> (sel[ch*DW +: DW] == '0));
    end
  end

endmodule

// File: rtl/chan_shift_unit.sv
module chan_shift_unit #(
  parameter int unsigned NCH   = 12,
  parameter int unsigned DW    = 4,
  parameter int unsigned MAX_W = 16,
  parameter int unsigned MAX_H = 16,
  localparam int unsigned VW = NCH * DW,
  localparam int unsigned CW = $clog2(MAX_W + 1),
  localparam int unsigned RW = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic [CW-1:0] img_w,
  input  logic [RW-1:0] img_h,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_data
);

  localparam int unsigned SIDE  = tapshift_pkg::TAP_SIDE;
  localparam int unsigned LINES = tapshift_pkg::LINE_COUNT;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic                      step, emit, real_px, col_write;
  logic [CW-1:0]             col_idx;
  logic [SIDE-1:0]           row_ok, col_ok;
  logic [LINES-1:0][VW-1:0]  rd_rows;
  logic [SIDE-1:0][VW-1:0]   col_new;
  logic [VW-1:0]             px_new, sel;
  logic [VW-1:0]             odat_q, odat_d;

  tapshift_scan_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i),
    .sof       (sof),
    .img_w     (img_w),
    .img_h     (img_h),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .step      (step),
    .emit      (emit),
    .real_px   (real_px),
    .col_write (col_write),
    .col_idx   (col_idx),
    .row_ok    (row_ok),
    .col_ok    (col_ok)
  );

  // padding positions enter the window as zero
  assign px_new = real_px ? in_data : '0;

  tapshift_line_store #(.MAX_W(MAX_W), .VW(VW)) u_lines (
    .clk     (clk),
    .wr_en   (col_write),
    .addr    (col_idx),
    .wr_data (px_new),
    .rd_rows (rd_rows)
  );

  assign col_new[2] = px_new;
  assign col_new[1] = rd_rows[0];
  assign col_new[0] = rd_rows[1];

  tapshift_window #(.NCH(NCH), .DW(DW)) u_win (
    .clk     (clk),
    .rst_n   (rst_i),
    .step    (step),
    .col_new (col_new),
    .row_ok  (row_ok),
    .col_ok  (col_ok),
    .sel     (sel)
  );

  always_comb begin
    odat_d = (step && emit) ? sel : odat_q;
  end

  always_ff @(posedge clk) begin
    odat_q <= odat_d;
  end

  assign out_data = odat_q;

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_ready) |=> $stable(out_data));

  p_sof_clean_r6: assert property (@(posedge clk) disable iff (!rst_i)
    sof |-> !in_valid);

endmodule

// File: tb/chan_shift_unit_test.sv
module chan_shift_unit_test;

  localparam int NCH  = 12;
  localparam int DW   = 4;
  localparam int MAXW = 16;
  localparam int MAXH = 16;
  localparam int VW   = NCH * DW;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int RW   = $clog2(MAXH + 1);

  // {width, height, seed, input gaps, output stalls}
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd5,  8'd4,  8'd1, 4'd0, 4'd0},
    {8'd1,  8'd1,  8'd2, 4'd0, 4'd0},
    {8'd16, 8'd3,  8'd3, 4'd1, 4'd1},
    {8'd3,  8'd7,  8'd4, 4'd1, 4'd0},
    {8'd2,  8'd2,  8'd5, 4'd0, 4'd1},
    {8'd7,  8'd1,  8'd6, 4'd1, 4'd1},
    {8'd1,  8'd5,  8'd7, 4'd0, 4'd1},
    {8'd16, 8'd16, 8'd8, 4'd1, 4'd1}
  };

  logic          clk;
  logic          rst_n;
  logic          sof;
  logic [CW-1:0] img_w;
  logic [RW-1:0] img_h;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [VW-1:0] in_data, out_data;

  int   nchk, nfail, cyc, fidx, oidx, fw, fh, fseed, t_start, t_end;
  bit   feeding, gap_on, stall_on, mon_on;
  logic [15:0] lfsr;

  chan_shift_unit #(.NCH(NCH), .DW(DW), .MAX_W(MAXW), .MAX_H(MAXH)) uut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .img_w(img_w), .img_h(img_h),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] px(int seed, int r, int c, int ch);
    return DW'((r * 7 + c * 3 + ch * 5 + seed * 11 + 1) % 16);
  endfunction

  function automatic logic [VW-1:0] pixel_vec(int idx, int w, int seed);
    logic [VW-1:0] v;
    int wd;
    wd = (w < 1) ? 1 : w;
    for (int ch = 0; ch < NCH; ch++) v[ch*DW +: DW] = px(seed, idx / wd, idx % wd, ch);
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_lane(int r, int c, int ch, int w, int h, int seed);
    int t, rr, cc;
    t  = ch % 9;
    rr = r + t / 3 - 1;
    cc = c + t % 3 - 1;
    if (rr < 0 || rr >= h || cc < 0 || cc >= w) return '0;
    return px(seed, rr, cc, ch);
  endfunction

  assign in_valid  = feeding && (fidx < fw * fh) && (!gap_on || lfsr[0]);
  assign in_data   = pixel_vec(fidx, fw, fseed);
  assign out_ready = !stall_on || lfsr[1];

  task automatic check_beat(int idx);
    logic [VW-1:0] ev;
    string tag;
    int r, c;
    nchk++;
    if (idx >= fw * fh) begin
      nfail++;
      $display("FAIL R4 extra beat %0d: got %h expected no beat", idx, out_data);
      return;
    end
    r = idx / fw;
    c = idx % fw;
    tag = "";
    for (int ch = 0; ch < NCH; ch++) begin
      ev[ch*DW +: DW] = exp_lane(r, c, ch, fw, fh, fseed);
      if (tag == "" && ev[ch*DW +: DW] != out_data[ch*DW +: DW]) begin
        int t, rr, cc;
        t  = ch % 9;
        rr = r + t / 3 - 1;
        cc = c + t % 3 - 1;
        if (t == 4) tag = "R3";
        else if (rr < 0 || rr >= fh || cc < 0 || cc >= fw) tag = "R2";
        else tag = "R1";
      end
    end
    if (tag != "") begin
      nfail++;
      $display("FAIL %s%s frame %0dx%0d pixel (%0d,%0d): got %h expected %h",
               tag, stall_on ? " R7" : "", fw, fh, r, c, out_data, ev);
    end
  endtask

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (sof) begin
      fidx    <= 0;
      oidx    <= 0;
      t_start <= cyc;
    end else begin
      if (in_valid && in_ready) fidx <= fidx + 1;
      if (out_valid && out_ready && mon_on) begin
        check_beat(oidx);
        if (oidx == fw * fh - 1) t_end <= cyc;
        oidx <= oidx + 1;
      end
    end
  end

  task automatic start_frame(int w, int h, int seed, bit gap, bit stall, bit mon);
    @(negedge clk);
    feeding  = 1'b0;
    fw       = w;
    fh       = h;
    fseed    = seed;
    gap_on   = gap;
    stall_on = stall;
    mon_on   = mon;
    img_w    = CW'(w);
    img_h    = RW'(h);
    sof      = 1'b1;
    @(negedge clk);
    sof      = 1'b0;
    feeding  = 1'b1;
  endtask

  task automatic run_frame(int w, int h, int seed, bit gap, bit stall);
    start_frame(w, h, seed, gap, stall, 1'b1);
    for (int k = 0; k < 6000 && oidx < w * h; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    feeding = 1'b0;
    nchk++;
    if (oidx != w * h || fidx != w * h) begin
      nfail++;
      $display("FAIL R4 R5 frame %0dx%0d beats out/in: got %0d/%0d expected %0d/%0d",
               w, h, oidx, fidx, w * h, w * h);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R4 watchdog: got no completion expected run to finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0; cyc = 0; fidx = 0; oidx = 0;
    fw = 1; fh = 1; fseed = 0; t_start = 0; t_end = 0;
    feeding = 1'b0; gap_on = 1'b0; stall_on = 1'b0; mon_on = 1'b1;
    lfsr = 16'hACE1;
    sof = 1'b0; img_w = '0; img_h = '0;
    rst_n = 1'b0;

    // R9: outputs quiet in reset
    repeat (3) @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      nfail++;
      $display("FAIL R9 in reset out_valid/in_ready: got %b/%b expected 0/0", out_valid, in_ready);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: offered input before any frame start is not taken
    fw = 4; fh = 4; feeding = 1'b1;
    nchk++;
    begin
      bit bad;
      bad = 1'b0;
      for (int k = 0; k < 6; k++) begin
        if (in_ready !== 1'b0 || out_valid !== 1'b0) bad = 1'b1;
        @(negedge clk);
      end
      if (bad || fidx != 0) begin
        nfail++;
        $display("FAIL R9 before frame start accepted beats: got %0d expected 0", fidx);
      end
    end
    feeding = 1'b0;

    // table of frames: sizes, gaps and stalls (R1 R2 R3 R4 R5 R7)
    for (int v = 0; v < NVEC; v++) begin
      run_frame(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                VEC[v][7:4] != 0, VEC[v][3:0] != 0);
    end

    // R8: steady-state rate on a free-flowing 4x3 frame
    run_frame(4, 3, 9, 1'b0, 1'b0);
    nchk++;
    if (t_end - t_start != (3 + 1) * (4 + 1) + 1) begin
      nfail++;
      $display("FAIL R8 edges from frame start to last beat: got %0d expected %0d",
               t_end - t_start, (3 + 1) * (4 + 1) + 1);
    end

    // R6: abort a frame after ten pixels, then restart with another size
    start_frame(6, 5, 12, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 200 && fidx < 10; k++) @(negedge clk);
    feeding = 1'b0;
    repeat (6) @(negedge clk);
    run_frame(4, 4, 13, 1'b1, 1'b1);

    // R6: back-to-back frame of the same size after a full one
    run_frame(4, 4, 14, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule